// File: doc/BRIEF.md
# Multiplexed Utility Bus Master

This block is the host-side controller for a byte-wide management bus on which address and data share the same eight pins. Attached physical-layer devices hold their registers behind it. Each device has its own active-low chip select. The host side issues one command at a time: a direction, a device select, a start address and a byte count. For writes the host supplies one data byte per bus transfer; for reads it receives one byte per transfer with a valid strobe.

A command begins with an address phase. The latch enable is held high while the master drives the address. The latch enable then falls, and the slave captures the address on that falling edge. A burst of data transfers follows, each framed by a low-going read or write strobe. Between one and thirty-two bytes move per command, and the slave advances its register address after every byte. On reads the master releases the shared bus while the read strobe is low, and it captures the slave's byte as the strobe rises.

Two small side functions share the block. A reset control bit, when written with one, drives an active-low reset pin low for at least sixteen clocks. An active-low interrupt input feeds a sticky flag that the host clears.

Top module: `mbus_master`

## Requirements
- R1: A command is accepted only when `busy` is low, `cmd_valid` is high and `cmd_sel` is below 13. `busy` rises in the next cycle and stays high for exactly 3*N+4 cycles, where N is the effective byte count. `done` is high for exactly one cycle, the last cycle in which `busy` is high.
- R2: The address phase lasts three cycles. For two cycles `ale` is high; for one further cycle `ale` is low and neither strobe is low. Throughout those three cycles `ad_oe` is high and `ad` carries `cmd_addr`. The first strobe goes low in the fourth busy cycle.
- R3: From the first address cycle through the last recovery cycle, exactly the chip select `cs_n[cmd_sel]` is low and all other chip selects are high. In the `done` cycle every chip select is high, and at no time are two chip selects low together.
- R4: On a write (`cmd_write`=1), each byte takes two cycles with `wr_n` low and then one cycle with `wr_n` high. During those cycles `ad_oe` is high and `ad` carries the byte. The byte is sampled from `wr_data` at the clock edge that drives `wr_n` low, and `wr_take` is high for the first `wr_n`-low cycle of each byte. `rd_n` stays high.
- R5: On a read (`cmd_write`=0), each byte takes two cycles with `rd_n` low and then one recovery cycle. `ad_oe` is low whenever `rd_n` is low. The bus value is captured into `rd_data` at the edge where `rd_n` rises, and `rd_valid` is high for exactly that recovery cycle. `wr_n` stays high.
- R6: A `cmd_len` of 0 moves one byte, and a `cmd_len` above 32 moves 32 bytes. Any other value moves exactly `cmd_len` bytes.
- R7: A `cmd_valid` presented while `busy` is high has no effect on the running burst and starts no later command. A command whose `cmd_sel` is 13 or above is ignored: `busy` stays low and every chip select stays high.
- R8: Pulsing `rst_wr` with `rst_bit`=1 drives `phy_rst_n` low from the next cycle for exactly 16 cycles. Pulsing `rst_wr` with `rst_bit`=0 leaves `phy_rst_n` high. A new write of 1 while the pulse runs restarts the 16-cycle count from that edge.
- R9: A high-to-low transition on `phy_irq_n` sets `irq_flag` in the next cycle. The flag stays set until `irq_clr` is high at a clock edge. Transitions that arrive while the flag is set are dropped. A transition sampled at the same edge as `irq_clr` leaves the flag set.
- R10: While `rst_n` is low and after it is released, with no activity: `busy`, `done`, `ale`, `ad_oe`, `rd_valid`, `wr_take` and `irq_flag` are 0, and `rd_n`, `wr_n`, `phy_rst_n` and every chip select are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_write | input | 1 | 1 = write burst, 0 = read burst |
| cmd_sel | input | 4 | Target device index, 0 to 12 |
| cmd_addr | input | 8 | Start register address |
| cmd_len | input | 6 | Byte count (0 means 1, above 32 means 32) |
| wr_data | input | 8 | Current write byte |
| wr_take | output | 1 | Write byte consumed; present the next one |
| rd_data | output | 8 | Last captured read byte |
| rd_valid | output | 1 | One-cycle strobe for a new `rd_data` |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| ale | output | 1 | Address latch enable, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| cs_n | output | 13 | Device chip selects, active low |
| ad | inout | 8 | Multiplexed address/data bus |
| ad_oe | output | 1 | High while the master drives `ad` |
| rst_wr | input | 1 | Reset control register write strobe |
| rst_bit | input | 1 | Value written to the reset control bit |
| phy_rst_n | output | 1 | Stretched device reset, active low |
| phy_irq_n | input | 1 | Device interrupt, active low |
| irq_clr | input | 1 | Host clear of the interrupt flag |
| irq_flag | output | 1 | Sticky interrupt flag |

## Verification
A new interrupt edge and the host's clear can land on the same clock edge, and the flag update must then resolve in favour of the new event. The bench sets the flag and returns the interrupt line high. At one falling clock edge it drives both the interrupt low and `irq_clr` high, then expects the flag still set one cycle later. In a separate step it clears without an edge and expects the flag to drop. A second overlap is a reset-bit write that arrives while a reset pulse is already running. There the bench counts the low cycles across both writes and expects the second write's 16 cycles to extend the pulse rather than add to it.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

    // Bus sequencer phases, in the order a command walks through them.
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ALE_HI  = 3'd1,
        ST_ALE_LO  = 3'd2,
        ST_STRB    = 3'd3,
        ST_RECOV   = 3'd4,
        ST_RELEASE = 3'd5
    } seq_state_e;

endpackage

// File: rtl/mbus_seq.sv
module mbus_seq
    import mbus_pkg::*;
#(
    parameter int DW         = 8,
    parameter int NCS        = 13,
    parameter int SEL_W      = 4,
    parameter int MAX_BURST  = 32,
    parameter int LEN_W      = 6,
    parameter int ALE_HI_CYC = 2,
    parameter int ALE_LO_CYC = 1,
    parameter int STRB_CYC   = 2,
    parameter int RECOV_CYC  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic             cmd_write,
    input  logic [SEL_W-1:0] cmd_sel,
    input  logic [DW-1:0]    cmd_addr,
    input  logic [LEN_W-1:0] cmd_len,
    input  logic [DW-1:0]    wr_data,
    output logic             wr_take,
    output logic [DW-1:0]    rd_data,
    output logic             rd_valid,
    output logic             busy,
    output logic             done,
    output logic             ale,
    output logic             rd_n,
    output logic             wr_n,
    output logic [DW-1:0]    ad_out,
    output logic             ad_oe,
    input  logic [DW-1:0]    ad_in,
    output logic             cs_en_nx,
    output logic [SEL_W-1:0] cs_sel_nx
);

    localparam int PH_SUM = ALE_HI_CYC + ALE_LO_CYC + STRB_CYC + RECOV_CYC;
    localparam int PH_W   = $clog2(PH_SUM + 1);

    typedef struct packed {
        seq_state_e       st;
        logic [PH_W-1:0]  ph;
        logic [LEN_W-1:0] left;
        logic             wr;
        logic [SEL_W-1:0] sel;
        logic [DW-1:0]    ad;
        logic [DW-1:0]    rdat;
        logic             ad_oe;
        logic             ale;
        logic             rd_n;
        logic             wr_n;
        logic             cs_en;
        logic             busy;
        logic             done;
        logic             wr_take;
        logic             rd_valid;
    } seq_t;

    seq_t q, d;
    logic             accept;
    logic [LEN_W-1:0] len_eff;

    always_comb begin
        if (cmd_len == '0) begin
            len_eff = LEN_W'(1);
        end else if (int'(cmd_len) > MAX_BURST) begin
            len_eff = LEN_W'(MAX_BURST);
        end else begin
            len_eff = cmd_len;
        end
    end

    assign accept = cmd_valid && (q.st == ST_IDLE) && (int'(cmd_sel) < NCS);

    always_comb begin
        d          = q;
        d.done     = 1'b0;
        d.wr_take  = 1'b0;
        d.rd_valid = 1'b0;

        case (q.st)
            ST_IDLE: begin
                if (accept) begin
                    d.st   = ST_ALE_HI;
                    d.ph   = PH_W'(ALE_HI_CYC - 1);
                    d.wr   = cmd_write;
                    d.sel  = cmd_sel;
                    d.ad   = cmd_addr;
                    d.left = len_eff;
                end
            end
            ST_ALE_HI: begin
                if (q.ph == '0) begin
                    d.st = ST_ALE_LO;
                    d.ph = PH_W'(ALE_LO_CYC - 1);
                end else begin
                    d.ph = q.ph - 1'b1;
                end
            end
            ST_ALE_LO: begin
                if (q.ph == '0) begin
                    d.st = ST_STRB;
                    d.ph = PH_W'(STRB_CYC - 1);
                    if (q.wr) begin
                        d.ad      = wr_data;
                        d.wr_take = 1'b1;
                    end
                end else begin
                    d.ph = q.ph - 1'b1;
                end
            end
            ST_STRB: begin
                if (q.ph == '0) begin
                    d.st = ST_RECOV;
                    d.ph = PH_W'(RECOV_CYC - 1);
                    if (!q.wr) begin
                        d.rdat     = ad_in;
                        d.rd_valid = 1'b1;
                    end
                end else begin
                    d.ph = q.ph - 1'b1;
                end
            end
            ST_RECOV: begin
                if (q.ph == '0) begin
                    if (q.left == LEN_W'(1)) begin
                        d.st   = ST_RELEASE;
                        d.done = 1'b1;
                    end else begin
                        d.left = q.left - 1'b1;
                        d.st   = ST_STRB;
                        d.ph   = PH_W'(STRB_CYC - 1);
                        if (q.wr) begin
                            d.ad      = wr_data;
                            d.wr_take = 1'b1;
                        end
                    end
                end else begin
                    d.ph = q.ph - 1'b1;
                end
            end
            ST_RELEASE: begin
                d.st = ST_IDLE;
            end
            default: begin
                d.st = ST_IDLE;
            end
        endcase

        // Pin values are derived from the next phase so they leave a flop.
        d.ale   = (d.st == ST_ALE_HI);
        d.cs_en = (d.st == ST_ALE_HI) || (d.st == ST_ALE_LO) ||
                  (d.st == ST_STRB)   || (d.st == ST_RECOV);
        d.rd_n  = !((d.st == ST_STRB) && !d.wr);
        d.wr_n  = !((d.st == ST_STRB) && d.wr);
        d.ad_oe = (d.st == ST_ALE_HI) || (d.st == ST_ALE_LO) ||
                  (d.wr && ((d.st == ST_STRB) || (d.st == ST_RECOV)));
        d.busy  = (d.st != ST_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.st       <= ST_IDLE;
            q.rd_n     <= 1'b1;
            q.wr_n     <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign wr_take   = q.wr_take;
    assign rd_data   = q.rdat;
    assign rd_valid  = q.rd_valid;
    assign busy      = q.busy;
    assign done      = q.done;
    assign ale       = q.ale;
    assign rd_n      = q.rd_n;
    assign wr_n      = q.wr_n;
    assign ad_out    = q.ad;
    assign ad_oe     = q.ad_oe;
    assign cs_en_nx  = d.cs_en;
    assign cs_sel_nx = d.sel;

endmodule

// File: rtl/mbus_cs_dec.sv
module mbus_cs_dec #(
    parameter int NCS   = 13,
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_en_d,
    input  logic [SEL_W-1:0] sel_d,
    output logic [NCS-1:0]   cs_n
);

    logic [NCS-1:0] cs_n_d, cs_n_q;

    for (genvar i = 0; i < NCS; i++) begin : g_line
        assign cs_n_d[i] = !(cs_en_d && (int'(sel_d) == i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n_q <= '1;
        end else begin
            cs_n_q <= cs_n_d;
        end
    end

    assign cs_n = cs_n_q;

endmodule

// File: rtl/mbus_rst_pulse.sv
module mbus_rst_pulse #(
    parameter int PULSE_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_wr,
    input  logic ctl_bit,
    output logic phy_rst_n
);

    localparam int CW = $clog2(PULSE_CYC + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          out_n;
    } rp_t;

    rp_t q, d;

    always_comb begin
        d = q;
        if (ctl_wr && ctl_bit) begin
            d.cnt = CW'(PULSE_CYC);
        end else if (q.cnt != '0) begin
            d.cnt = q.cnt - 1'b1;
        end
        d.out_n = (d.cnt == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cnt   <= '0;
            q.out_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign phy_rst_n = q.out_n;

endmodule

// File: rtl/mbus_irq_latch.sv
module mbus_irq_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_n,
    input  logic clr,
    output logic flag
);

    typedef struct packed {
        logic prev;
        logic flag;
    } il_t;

    il_t  q, d;
    logic event_hit;

    assign event_hit = q.prev && !irq_n;

    always_comb begin
        d      = q;
        d.prev = irq_n;
        if (q.flag) begin
            // An edge in the clearing cycle is kept; otherwise edges are dropped.
            d.flag = clr ? event_hit : 1'b1;
        end else begin
            d.flag = event_hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.prev <= 1'b1;
            q.flag <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign flag = q.flag;

endmodule

// File: rtl/mbus_master.sv
module mbus_master #(
    parameter int DW         = 8,
    parameter int NCS        = 13,
    parameter int MAX_BURST  = 32,
    parameter int RST_PULSE  = 16,
    parameter int ALE_HI_CYC = 2,
    parameter int ALE_LO_CYC = 1,
    parameter int STRB_CYC   = 2,
    parameter int RECOV_CYC  = 1,
    localparam int SEL_W     = $clog2(NCS),
    localparam int LEN_W     = $clog2(MAX_BURST + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic             cmd_write,
    input  logic [SEL_W-1:0] cmd_sel,
    input  logic [DW-1:0]    cmd_addr,
    input  logic [LEN_W-1:0] cmd_len,
    input  logic [DW-1:0]    wr_data,
    output logic             wr_take,
    output logic [DW-1:0]    rd_data,
    output logic             rd_valid,
    output logic             busy,
    output logic             done,
    output logic             ale,
    output logic             rd_n,
    output logic             wr_n,
    output logic [NCS-1:0]   cs_n,
    inout  wire  [DW-1:0]    ad,
    output logic             ad_oe,
    input  logic             rst_wr,
    input  logic             rst_bit,
    output logic             phy_rst_n,
    input  logic             phy_irq_n,
    input  logic             irq_clr,
    output logic             irq_flag
);

    logic [DW-1:0]    ad_out;
    logic [DW-1:0]    ad_in;
    logic             cs_en_nx;
    logic [SEL_W-1:0] cs_sel_nx;

    assign ad    = ad_oe ? ad_out : {DW{1'bz}};
    assign ad_in = ad;

    mbus_seq #(
        .DW(DW), .NCS(NCS), .SEL_W(SEL_W), .MAX_BURST(MAX_BURST), .LEN_W(LEN_W),
        .ALE_HI_CYC(ALE_HI_CYC), .ALE_LO_CYC(ALE_LO_CYC),
        .STRB_CYC(STRB_CYC), .RECOV_CYC(RECOV_CYC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_sel(cmd_sel),
        .cmd_addr(cmd_addr), .cmd_len(cmd_len),
        .wr_data(wr_data), .wr_take(wr_take),
        .rd_data(rd_data), .rd_valid(rd_valid),
        .busy(busy), .done(done),
        .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
        .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
        .cs_en_nx(cs_en_nx), .cs_sel_nx(cs_sel_nx)
    );

    mbus_cs_dec #(.NCS(NCS), .SEL_W(SEL_W)) u_cs (
        .clk(clk), .rst_n(rst_n),
        .cs_en_d(cs_en_nx), .sel_d(cs_sel_nx), .cs_n(cs_n)
    );

    mbus_rst_pulse #(.PULSE_CYC(RST_PULSE)) u_rst (
        .clk(clk), .rst_n(rst_n),
        .ctl_wr(rst_wr), .ctl_bit(rst_bit), .phy_rst_n(phy_rst_n)
    );

    mbus_irq_latch u_irq (
        .clk(clk), .rst_n(rst_n),
        .irq_n(phy_irq_n), .clr(irq_clr), .flag(irq_flag)
    );

endmodule

// File: rtl/mbus_master_chk.sv
module mbus_master_chk #(
    parameter int NCS       = 13,
    parameter int RST_PULSE = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCS-1:0] cs_n,
    input logic           ale,
    input logic           rd_n,
    input logic           wr_n,
    input logic           ad_oe,
    input logic           busy,
    input logic           done,
    input logic           phy_rst_n,
    input logic           irq_flag,
    input logic           irq_clr
);

    localparam int RW = $clog2(RST_PULSE + 2);

    logic [RW-1:0] low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run <= '0;
        end else if (!phy_rst_n) begin
            if (int'(low_run) < RST_PULSE + 1) low_run <= low_run + 1'b1;
        end else begin
            low_run <= '0;
        end
    end

    // R3
    one_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~cs_n) <= 1);

    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    // R2
    strobe_after_ale_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |-> (!ale && (cs_n != '1)));

    // R2
    ale_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (ad_oe && busy));

    // R5
    read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);

    // R1
    done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    // R1
    done_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R8
    rst_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phy_rst_n) |-> (int'(low_run) >= RST_PULSE));

    // R9
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !irq_clr) |=> irq_flag);

endmodule

bind mbus_master mbus_master_chk #(.NCS(NCS), .RST_PULSE(RST_PULSE)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
    .ad_oe(ad_oe), .busy(busy), .done(done), .phy_rst_n(phy_rst_n),
    .irq_flag(irq_flag), .irq_clr(irq_clr)
);

// File: tb/sim_mbus_master.sv
`timescale 1ns/1ps
module sim_mbus_master;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_write = 1'b0;
    logic [3:0]  cmd_sel = '0;
    logic [7:0]  cmd_addr = '0;
    logic [5:0]  cmd_len = '0;
    logic [7:0]  wr_data;
    logic        wr_take;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic        busy;
    logic        done;
    logic        ale;
    logic        rd_n;
    logic        wr_n;
    logic [12:0] cs_n;
    wire  [7:0]  ad;
    logic        ad_oe;
    logic        rst_wr = 1'b0;
    logic        rst_bit = 1'b0;
    logic        phy_rst_n;
    logic        phy_irq_n = 1'b1;
    logic        irq_clr = 1'b0;
    logic        irq_flag;

    always #2.5 clk = ~clk;

    mbus_master u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_sel(cmd_sel), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
        .wr_data(wr_data), .wr_take(wr_take), .rd_data(rd_data), .rd_valid(rd_valid),
        .busy(busy), .done(done), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .cs_n(cs_n),
        .ad(ad), .ad_oe(ad_oe), .rst_wr(rst_wr), .rst_bit(rst_bit),
        .phy_rst_n(phy_rst_n), .phy_irq_n(phy_irq_n), .irq_clr(irq_clr),
        .irq_flag(irq_flag)
    );

    int tests = 0;
    int fails = 0;

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] rdpat(input logic [3:0] s, input logic [7:0] a);
        return a ^ {s, 4'hA};
    endfunction

    function automatic logic [7:0] wpat(input int k, input logic [7:0] a);
        return a ^ 8'h3C ^ (8'(k) * 8'd29);
    endfunction

    // Slave model and monitor state
    logic       slave_oe = 1'b0;
    logic [7:0] slave_data = '0;
    logic [7:0] slv_addr = '0;
    int         ptr = 0;
    logic       prev_strb_lo = 1'b0;
    logic [7:0] wrx [32];

    logic [3:0] cur_sel = '0;
    logic [7:0] cur_addr = '0;
    logic       cur_write = 1'b0;
    int         n_exp = 1;
    int         widx = 0;

    int busy_cnt, ale_cnt, phase_bad, cs_bad, rlo_cnt, wlo_cnt, hiz_bad;
    int rdv_cnt, rd_bad, wt_cnt, done_cnt, wr_bad, rst_low_cnt;
    logic done_seen;

    assign ad      = slave_oe ? slave_data : 8'hzz;
    assign wr_data = wpat(widx, cur_addr);

    always @(negedge clk) begin
        int idx;
        logic strb_lo;
        logic [12:0] cs_exp;
        idx     = busy_cnt;
        strb_lo = !rd_n || !wr_n;
        if (!phy_rst_n) rst_low_cnt++;
        if (ale) slv_addr = ad;
        if (prev_strb_lo && !strb_lo) ptr++;
        prev_strb_lo = strb_lo;
        if (!rd_n) begin
            slave_oe   = 1'b1;
            slave_data = rdpat(cur_sel, slv_addr + 8'(ptr));
        end else begin
            slave_oe = 1'b0;
        end
        if (!wr_n && ptr < 32) wrx[ptr] = ad;
        if (!wr_n && !ad_oe) wr_bad++;
        if (!rd_n && ad_oe) hiz_bad++;
        if (!rd_n) rlo_cnt++;
        if (!wr_n) wlo_cnt++;
        if (ale) ale_cnt++;
        if (wr_take) begin wt_cnt++; widx++; end
        if (rd_valid) begin
            if (rd_data !== rdpat(cur_sel, cur_addr + 8'(rdv_cnt))) rd_bad++;
            rdv_cnt++;
        end
        if (done) begin
            done_cnt++;
            done_seen = 1'b1;
            if (idx != 3 * n_exp + 3) phase_bad++;
        end
        if (busy) begin
            cs_exp = ~(13'd1 << cur_sel);
            if (idx < 3 * n_exp + 3) begin
                if (cs_n !== cs_exp) cs_bad++;
            end else if (cs_n !== 13'h1FFF) begin
                cs_bad++;
            end
            if (idx <= 1 && !(ale && ad_oe && ad === cur_addr)) phase_bad++;
            if (idx == 2 && !(!ale && ad_oe && ad === cur_addr && rd_n && wr_n)) phase_bad++;
            if (idx <= 2 && strb_lo) phase_bad++;
            if (idx == 3 && !(cur_write ? !wr_n : !rd_n)) phase_bad++;
            busy_cnt++;
        end
    end

    task automatic clear_mon();
        busy_cnt = 0; ale_cnt = 0; phase_bad = 0; cs_bad = 0; rlo_cnt = 0;
        wlo_cnt = 0; hiz_bad = 0; rdv_cnt = 0; rd_bad = 0; wt_cnt = 0;
        done_cnt = 0; wr_bad = 0; ptr = 0; widx = 0; done_seen = 1'b0;
        for (int k = 0; k < 32; k++) wrx[k] = 8'h00;
    endtask

    task automatic run_cmd(input logic w, input logic [3:0] s, input logic [7:0] a,
                           input logic [5:0] len, input logic poke);
        int it;
        int wmis;
        n_exp     = (len == 0) ? 1 : ((len > 32) ? 32 : int'(len));
        @(negedge clk);
        clear_mon();
        cur_sel   = s;
        cur_addr  = a;
        cur_write = w;
        cmd_write = w;
        cmd_sel   = s;
        cmd_addr  = a;
        cmd_len   = len;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        it = 0;
        while (!done_seen) begin
            @(negedge clk);
            it++;
            if (poke && it == 3) begin
                cmd_valid = 1'b1; cmd_write = ~w; cmd_sel = 4'd9; cmd_len = 6'd5;
            end
            if (poke && it == 5) cmd_valid = 1'b0;
            if (it > 200) break;
        end
        repeat (3) @(negedge clk);
        #1;
        check("R1 busy length", busy_cnt, 3 * n_exp + 4);
        check("R1 done pulses", done_cnt, 1);
        check("R1 idle after", int'(busy), 0);
        check("R2 ale cycles", ale_cnt, 2);
        check("R2 phase order", phase_bad, 0);
        check("R3 chip select", cs_bad, 0);
        if (w) begin
            wmis = 0;
            for (int k = 0; k < n_exp; k++) if (wrx[k] !== wpat(k, a)) wmis++;
            check("R4 write strobe cycles", wlo_cnt, 2 * n_exp);
            check("R4 write takes", wt_cnt, n_exp);
            check("R4 write data", wmis, 0);
            check("R4 write drive", wr_bad, 0);
            check("R4 no read strobe", rlo_cnt, 0);
            check("R6 byte count", wt_cnt, n_exp);
        end else begin
            check("R5 read strobe cycles", rlo_cnt, 2 * n_exp);
            check("R5 read valids", rdv_cnt, n_exp);
            check("R5 read data", rd_bad, 0);
            check("R5 bus released", hiz_bad, 0);
            check("R5 no write strobe", wlo_cnt, 0);
            check("R6 byte count", rdv_cnt, n_exp);
        end
    endtask

    // {write, sel, addr, len}
    localparam logic [18:0] VEC [7] = '{
        {1'b1, 4'd0,  8'h10, 6'd1},
        {1'b0, 4'd12, 8'hF0, 6'd3},
        {1'b1, 4'd5,  8'hFE, 6'd4},
        {1'b0, 4'd7,  8'h00, 6'd0},
        {1'b1, 4'd3,  8'h40, 6'd32},
        {1'b0, 4'd1,  8'h80, 6'd40},
        {1'b0, 4'd9,  8'h22, 6'd32}
    };

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        clear_mon();
        rst_low_cnt = 0;
        repeat (3) @(negedge clk);
        // R10 values under reset
        check("R10 busy in reset", int'(busy), 0);
        check("R10 cs in reset", int'(cs_n), 13'h1FFF);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R10 busy", int'(busy), 0);
        check("R10 done", int'(done), 0);
        check("R10 ale", int'(ale), 0);
        check("R10 strobes", int'({rd_n, wr_n}), 3);
        check("R10 cs", int'(cs_n), 13'h1FFF);
        check("R10 ad_oe", int'(ad_oe), 0);
        check("R10 phy_rst_n", int'(phy_rst_n), 1);
        check("R10 irq_flag", int'(irq_flag), 0);
        check("R10 valids", int'({rd_valid, wr_take}), 0);

        for (int v = 0; v < 7; v++) begin
            run_cmd(VEC[v][18], VEC[v][17:14], VEC[v][13:6], VEC[v][5:0], 1'b0);
        end

        // R7 command during busy is ignored
        run_cmd(1'b1, 4'd2, 8'h55, 6'd2, 1'b1);
        repeat (6) @(negedge clk);
        check("R7 no late start", int'(busy), 0);
        check("R7 cs idle", int'(cs_n), 13'h1FFF);

        // R7 out-of-range select is ignored
        begin
            int seen;
            seen = 0;
            cmd_sel = 4'd13; cmd_write = 1'b0; cmd_len = 6'd1; cmd_valid = 1'b1;
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                if (k == 2) cmd_sel = 4'd15;
                if (busy || cs_n != 13'h1FFF) seen++;
            end
            cmd_valid = 1'b0;
            repeat (3) @(negedge clk);
            if (busy || cs_n != 13'h1FFF) seen++;
            check("R7 bad select ignored", seen, 0);
        end

        // R8 reset pulse width
        rst_low_cnt = 0;
        rst_wr = 1'b1; rst_bit = 1'b1;
        @(negedge clk);
        rst_wr = 1'b0; rst_bit = 1'b0;
        check("R8 low next cycle", int'(phy_rst_n), 0);
        repeat (30) @(negedge clk);
        check("R8 pulse length", rst_low_cnt, 16);

        // R8 writing zero has no effect
        rst_low_cnt = 0;
        rst_wr = 1'b1; rst_bit = 1'b0;
        @(negedge clk);
        rst_wr = 1'b0;
        repeat (20) @(negedge clk);
        check("R8 zero ignored", rst_low_cnt, 0);

        // R8 retrigger while low restarts the count
        rst_low_cnt = 0;
        rst_wr = 1'b1; rst_bit = 1'b1;
        @(negedge clk);
        rst_wr = 1'b0;
        repeat (8) @(negedge clk);
        rst_wr = 1'b1;
        @(negedge clk);
        rst_wr = 1'b0; rst_bit = 1'b0;
        repeat (40) @(negedge clk);
        check("R8 retrigger length", rst_low_cnt, 25);

        // R9 interrupt flag
        phy_irq_n = 1'b0;
        @(negedge clk);
        check("R9 set on edge", int'(irq_flag), 1);
        repeat (3) @(negedge clk);
        check("R9 held", int'(irq_flag), 1);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        check("R9 cleared with level low", int'(irq_flag), 0);
        repeat (2) @(negedge clk);
        check("R9 level not an event", int'(irq_flag), 0);
        phy_irq_n = 1'b1;
        @(negedge clk);
        phy_irq_n = 1'b0;
        @(negedge clk);
        check("R9 second edge", int'(irq_flag), 1);
        phy_irq_n = 1'b1;
        @(negedge clk);
        phy_irq_n = 1'b0;
        @(negedge clk);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        check("R9 edge while set dropped", int'(irq_flag), 0);
        phy_irq_n = 1'b0;
        @(negedge clk);
        phy_irq_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R9 flag before overlap", int'(irq_flag), 0);
        phy_irq_n = 1'b0;
        @(negedge clk);
        phy_irq_n = 1'b1;
        @(negedge clk);
        check("R9 set before overlap", int'(irq_flag), 1);
        phy_irq_n = 1'b0; irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        check("R9 edge with clear kept", int'(irq_flag), 1);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule